// File: doc/BRIEF.md
# Sector Search and Read Sequencer

This block runs the read side of a floppy-style disk controller for one track. Software arms it with a first sector number and a count of sectors, then pulses start. The sequencer waits for the drive's sync strobe and then watches each sector header that the drive model presents. Every examined header is copied into two status registers and raises an ID-read interrupt flag. When a header carries the sector the sequencer is looking for, the sector's payload is passed byte by byte from the drive's data stream to a DMA-style valid/ready output.

After each full sector the remaining count drops by one. If sectors remain, the wanted sector number moves to the next one and the header search resumes. Otherwise the access ends and a sector-done interrupt flag is raised. A stop pulse abandons the access at any point. Rotational timing, write mode and checksum checking are outside the block: the drive model supplies the strobes, and the valid bit of the sector status is always reported set.

Top module: `sector_read_seq`

## Requirements
- R1: After reset, busy, both interrupt flags, dmaValid and srcReady are 0, and curTrack and curSector read 0.
- R2: A start pulse is accepted only when the sequencer is idle, writeMode is 0 and stepBusy is 0. A start under any other condition has no effect: an idle sequencer stays idle, and a running one keeps its wanted sector and remaining count.
- R3: An accepted start sets busy from the next cycle and loads the wanted sector from firstSector and the remaining count from sectorCount. Headers are ignored until a syncStrobe has been seen.
- R4: Each header taken during the search loads curTrack with {hdrSide, hdrTrack} (side in bit 7) and curSector with {1, hdrSector} (bit 7 set as the checksum-valid mark), and sets idReadFlag, all visible the cycle after hdrValid.
- R5: A header whose sector number equals the wanted sector starts the payload transfer; any other header leaves the sequencer searching with no output traffic.
- R6: During a transfer dmaValid equals srcValid, srcReady equals dmaReady and dmaData equals srcData; the byte count advances only on a cycle where srcValid and dmaReady are both 1, and the transfer ends after exactly SECTOR_BYTES (default 512) accepted bytes. Outside a transfer dmaValid and srcReady are 0.
- R7: At the end of each sector the remaining count drops by one. If this was the last sector (count 1, or 0 at start), busy returns to 0 and sectorDoneFlag is set; otherwise the wanted sector becomes the previous one plus 1, wrapping from 127 to 0, and the search resumes.
- R8: A stop pulse returns the sequencer to idle from any state on the next cycle, abandoning any sync wait, search or partial transfer; stop wins over a same-cycle start.
- R9: irqClear clears both interrupt flags; a flag being set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Request to begin a read access |
| stopPulse | input | 1 | Abandon the access and go idle |
| writeMode | input | 1 | Write selected; blocks a start |
| stepBusy | input | 1 | Head stepping in progress; blocks a start |
| firstSector | input | 7 | First sector to read, sampled at start |
| sectorCount | input | 8 | Number of sectors to read, sampled at start |
| syncStrobe | input | 1 | Drive reports disk sync |
| hdrValid | input | 1 | A sector header is present this cycle |
| hdrSide | input | 1 | Header side bit |
| hdrTrack | input | 7 | Header track number |
| hdrSector | input | 7 | Header sector number |
| srcValid | input | 1 | Drive payload byte available |
| srcData | input | 8 | Drive payload byte |
| srcReady | output | 1 | Payload byte taken |
| dmaValid | output | 1 | DMA output byte valid |
| dmaData | output | 8 | DMA output byte |
| dmaReady | input | 1 | DMA sink accepts a byte |
| irqClear | input | 1 | Clear both interrupt flags |
| busy | output | 1 | Access in progress |
| curTrack | output | 8 | Last header's side and track |
| curSector | output | 8 | Valid mark and last header's sector |
| idReadFlag | output | 1 | A header has been examined |
| sectorDoneFlag | output | 1 | The last sector of the run finished |

## Verification
The bench sweeps several first-sector values, including 126 and 127 so the wanted sector wraps to 0, against run lengths of one to three sectors, with DMA back-pressure stalls in every transfer; a design that counted offered bytes instead of accepted ones, or that advanced the wanted sector wrongly, would stream too few bytes or never match the next header. It checks that headers arriving before sync are not captured, which a design entering the search at once would get wrong. It pulses start during a running access with a different first sector and shows the old wanted sector still matches, and it stops the sequencer in the sync wait and mid-sector to show the output goes silent and no later header is captured.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SYNC   = 2'd1,
    ST_SEARCH = 2'd2,
    ST_XFER   = 2'd3
  } seqState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadStart;  // capture first sector and count, clear byte count
    logic capHdr;     // copy header into status registers, raise ID flag
    logic byteTaken;  // one payload byte accepted
    logic sectorEnd;  // last byte of a sector accepted
    logic doneSet;    // raise the sector-done flag
  } seqCmd_t;

endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      stopPulse,
  input  logic      writeMode,
  input  logic      stepBusy,
  input  logic      syncStrobe,
  input  logic      hdrValid,
  input  logic      srcValid,
  input  logic      dmaReady,
  input  logic      hdrMatch,
  input  logic      lastByte,
  input  logic      lastSector,
  output seqCmd_t   cmd,
  output seqState_t state
);

  seqState_t nextState;

  always_comb begin
    nextState = state;
    cmd       = '0;
    if (stopPulse) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startPulse && !writeMode && !stepBusy) begin
            nextState     = ST_SYNC;
            cmd.loadStart = 1'b1;
          end
        end
        ST_SYNC: begin
          if (syncStrobe) nextState = ST_SEARCH;
        end
        ST_SEARCH: begin
          if (hdrValid) begin
            cmd.capHdr = 1'b1;
            if (hdrMatch) nextState = ST_XFER;
          end
        end
        ST_XFER: begin
          if (srcValid && dmaReady) begin
            cmd.byteTaken = 1'b1;
            if (lastByte) begin
              cmd.sectorEnd = 1'b1;
              if (lastSector) begin
                nextState   = ST_IDLE;
                cmd.doneSet = 1'b1;
              end else begin
                nextState = ST_SEARCH;
              end
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SEC_W        = 7,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCmd_t          cmd,
  input  logic [SEC_W-1:0] firstSector,
  input  logic [CNT_W-1:0] sectorCount,
  input  logic             hdrSide,
  input  logic [SEC_W-1:0] hdrTrack,
  input  logic [SEC_W-1:0] hdrSector,
  input  logic             irqClear,
  output logic             hdrMatch,
  output logic             lastByte,
  output logic             lastSector,
  output logic [SEC_W:0]   curTrack,
  output logic [SEC_W:0]   curSector,
  output logic             idReadFlag,
  output logic             sectorDoneFlag
);

  localparam int BYTE_CNT_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1;
  localparam logic [BYTE_CNT_W-1:0] LAST_BYTE = BYTE_CNT_W'(SECTOR_BYTES - 1);

  logic [SEC_W-1:0]      targetSec;
  logic [CNT_W-1:0]      remCount;
  logic [BYTE_CNT_W-1:0] byteCnt;

  assign hdrMatch   = (hdrSector == targetSec);
  assign lastByte   = (byteCnt == LAST_BYTE);
  assign lastSector = (remCount <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetSec <= '0;
      remCount  <= '0;
      byteCnt   <= '0;
    end else if (cmd.loadStart) begin
      targetSec <= firstSector;
      remCount  <= sectorCount;
      byteCnt   <= '0;
    end else if (cmd.sectorEnd) begin
      targetSec <= targetSec + 1'b1;
      remCount  <= remCount - 1'b1;
      byteCnt   <= '0;
    end else if (cmd.byteTaken) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTrack  <= '0;
      curSector <= '0;
    end else if (cmd.capHdr) begin
      curTrack  <= {hdrSide, hdrTrack};
      curSector <= {1'b1, hdrSector};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReadFlag     <= 1'b0;
      sectorDoneFlag <= 1'b0;
    end else begin
      if (cmd.capHdr)    idReadFlag <= 1'b1;
      else if (irqClear) idReadFlag <= 1'b0;
      if (cmd.doneSet)   sectorDoneFlag <= 1'b1;
      else if (irqClear) sectorDoneFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/sector_read_seq.sv
module sector_read_seq
  import srs_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SEC_W        = 7,
  parameter int CNT_W        = 8,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic              writeMode,
  input  logic              stepBusy,
  input  logic [SEC_W-1:0]  firstSector,
  input  logic [CNT_W-1:0]  sectorCount,
  input  logic              syncStrobe,
  input  logic              hdrValid,
  input  logic              hdrSide,
  input  logic [SEC_W-1:0]  hdrTrack,
  input  logic [SEC_W-1:0]  hdrSector,
  input  logic              srcValid,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcReady,
  output logic              dmaValid,
  output logic [DATA_W-1:0] dmaData,
  input  logic              dmaReady,
  input  logic              irqClear,
  output logic              busy,
  output logic [SEC_W:0]    curTrack,
  output logic [SEC_W:0]    curSector,
  output logic              idReadFlag,
  output logic              sectorDoneFlag
);

  seqCmd_t   seqCmd;
  seqState_t seqState;
  logic      hdrMatch;
  logic      lastByte;
  logic      lastSector;
  logic      xferOn;

  srs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .writeMode  (writeMode),
    .stepBusy   (stepBusy),
    .syncStrobe (syncStrobe),
    .hdrValid   (hdrValid),
    .srcValid   (srcValid),
    .dmaReady   (dmaReady),
    .hdrMatch   (hdrMatch),
    .lastByte   (lastByte),
    .lastSector (lastSector),
    .cmd        (seqCmd),
    .state      (seqState)
  );

  srs_datapath #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .SEC_W        (SEC_W),
    .CNT_W        (CNT_W)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .cmd            (seqCmd),
    .firstSector    (firstSector),
    .sectorCount    (sectorCount),
    .hdrSide        (hdrSide),
    .hdrTrack       (hdrTrack),
    .hdrSector      (hdrSector),
    .irqClear       (irqClear),
    .hdrMatch       (hdrMatch),
    .lastByte       (lastByte),
    .lastSector     (lastSector),
    .curTrack       (curTrack),
    .curSector      (curSector),
    .idReadFlag     (idReadFlag),
    .sectorDoneFlag (sectorDoneFlag)
  );

  assign xferOn   = (seqState == ST_XFER);
  assign busy     = (seqState != ST_IDLE);
  assign dmaValid = srcValid & xferOn;
  assign srcReady = dmaReady & xferOn;
  assign dmaData  = srcData;

endmodule

// File: rtl/sector_read_seq_chk.sv
module sector_read_seq_chk
  import srs_pkg::*;
#(
  parameter int SEC_W = 7
) (
  input logic           clk,
  input logic           rstN,
  input logic           startPulse,
  input logic           stopPulse,
  input logic           writeMode,
  input logic           stepBusy,
  input logic           syncStrobe,
  input logic           hdrValid,
  input logic           srcValid,
  input logic           dmaValid,
  input logic           irqClear,
  input logic           idReadFlag,
  input logic [SEC_W:0] curSector,
  input seqState_t      seqState
);

  // R2: without a legal start the idle state is kept
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_IDLE && (!startPulse || writeMode || stepBusy))
      |=> (seqState == ST_IDLE));

  // R3: no search before the sync strobe
  p_wait_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_SYNC && !syncStrobe && !stopPulse)
      |=> (seqState == ST_SYNC));

  // R4: a header taken in the search raises the flag and the valid mark
  p_hdr_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_SEARCH && hdrValid && !stopPulse)
      |=> (idReadFlag && curSector[SEC_W]));

  // R6: output traffic only while transferring
  p_dma_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid |-> (seqState == ST_XFER && srcValid));

  // R8: stop always lands in idle
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> (seqState == ST_IDLE));

  // R9: clear without a concurrent header drops the ID flag
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !(seqState == ST_SEARCH && hdrValid && !stopPulse))
      |=> !idReadFlag);

endmodule

bind sector_read_seq sector_read_seq_chk #(.SEC_W(SEC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .stopPulse  (stopPulse),
  .writeMode  (writeMode),
  .stepBusy   (stepBusy),
  .syncStrobe (syncStrobe),
  .hdrValid   (hdrValid),
  .srcValid   (srcValid),
  .dmaValid   (dmaValid),
  .irqClear   (irqClear),
  .idReadFlag (idReadFlag),
  .curSector  (curSector),
  .seqState   (seqState)
);

// File: tb/sector_read_seq_bench.sv
module sector_read_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 16;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0, stopPulse = 1'b0, writeMode = 1'b0, stepBusy = 1'b0;
  logic [6:0] firstSector = '0;
  logic [7:0] sectorCount = '0;
  logic       syncStrobe = 1'b0, hdrValid = 1'b0, hdrSide = 1'b0;
  logic [6:0] hdrTrack = '0, hdrSector = '0;
  logic       srcValid = 1'b0;
  logic [7:0] srcData = '0;
  logic       srcReady, dmaValid, dmaReady = 1'b0;
  logic [7:0] dmaData;
  logic       irqClear = 1'b0;
  logic       busy, idReadFlag, sectorDoneFlag;
  logic [7:0] curTrack, curSector;

  int errors = 0;
  int checks = 0;

  sector_read_seq #(.SECTOR_BYTES(NB)) u_sector_read_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .writeMode(writeMode), .stepBusy(stepBusy), .firstSector(firstSector),
    .sectorCount(sectorCount), .syncStrobe(syncStrobe), .hdrValid(hdrValid),
    .hdrSide(hdrSide), .hdrTrack(hdrTrack), .hdrSector(hdrSector),
    .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady),
    .dmaValid(dmaValid), .dmaData(dmaData), .dmaReady(dmaReady),
    .irqClear(irqClear), .busy(busy), .curTrack(curTrack), .curSector(curSector),
    .idReadFlag(idReadFlag), .sectorDoneFlag(sectorDoneFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=%0d cycles expected=<%0d", WATCHDOG, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doStart(input logic [6:0] first, input logic [7:0] cnt);
    firstSector = first;
    sectorCount = cnt;
    startPulse  = 1'b1;
    tick();
    startPulse  = 1'b0;
  endtask

  task automatic doSync();
    syncStrobe = 1'b1;
    tick();
    syncStrobe = 1'b0;
  endtask

  task automatic doHeader(input logic side, input logic [6:0] trk, input logic [6:0] sec);
    hdrValid  = 1'b1;
    hdrSide   = side;
    hdrTrack  = trk;
    hdrSector = sec;
    tick();
    hdrValid = 1'b0;
  endtask

  task automatic clearFlags();
    irqClear = 1'b1;
    tick();
    irqClear = 1'b0;
  endtask

  // Offer data with a stall pattern; expect exactly NB accepted bytes
  task automatic streamSector(input int stallPhase);
    int taken = 0;
    int cyc = 0;
    while (taken < NB && cyc < 4 * NB) begin
      srcValid = 1'b1;
      srcData  = 8'(cyc * 7 + 3);
      dmaReady = ((cyc + stallPhase) % 3) != 2;
      #1;
      chk("R6", "dmaValid during transfer", dmaValid, 1'b1);
      chk("R6", "srcReady follows dmaReady", srcReady, dmaReady);
      if (cyc == 0) chk("R6", "dmaData passes srcData", dmaData, srcData);
      if (dmaReady) taken++;
      cyc++;
      tick();
    end
    srcValid = 1'b1;
    dmaReady = 1'b1;
    #1;
    chk("R6", "no traffic after sector bytes", dmaValid, 1'b0);
    srcValid = 1'b0;
    dmaReady = 1'b0;
  endtask

  task automatic expectSilent(input string req, input string what);
    srcValid = 1'b1;
    dmaReady = 1'b1;
    #1;
    chk(req, what, dmaValid, 1'b0);
    srcValid = 1'b0;
    dmaReady = 1'b0;
  endtask

  initial begin
    tick();
    tick();
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "idReadFlag", idReadFlag, 1'b0);
    chk("R1", "sectorDoneFlag", sectorDoneFlag, 1'b0);
    chk("R1", "curTrack", curTrack, 8'h00);
    chk("R1", "curSector", curSector, 8'h00);
    chk("R1", "dmaValid", dmaValid, 1'b0);
    chk("R1", "srcReady", srcReady, 1'b0);

    // R2: blocked starts
    writeMode = 1'b1;
    doStart(7'd5, 8'd1);
    chk("R2", "start ignored in write mode", busy, 1'b0);
    writeMode = 1'b0;
    stepBusy = 1'b1;
    doStart(7'd5, 8'd1);
    chk("R2", "start ignored while stepping", busy, 1'b0);
    stepBusy = 1'b0;

    // R3: accepted start, headers ignored before sync
    doStart(7'd5, 8'd2);
    chk("R3", "busy after start", busy, 1'b1);
    doHeader(1'b0, 7'd9, 7'd5);
    chk("R3", "header before sync not captured", curSector, 8'h00);
    chk("R3", "no ID flag before sync", idReadFlag, 1'b0);
    expectSilent("R3", "no transfer before sync");
    doSync();

    // R4/R5: mismatching header captured, no transfer
    doHeader(1'b1, 7'd10, 7'd3);
    chk("R4", "curTrack packs side and track", curTrack, 8'h8A);
    chk("R4", "curSector has valid mark", curSector, 8'h83);
    chk("R4", "ID flag set", idReadFlag, 1'b1);
    expectSilent("R5", "mismatch keeps searching");
    chk("R5", "still busy while searching", busy, 1'b1);

    // R9: clear
    clearFlags();
    chk("R9", "ID flag cleared", idReadFlag, 1'b0);

    // R5/R6/R7: matching header, then chained target 6
    doHeader(1'b0, 7'd10, 7'd5);
    chk("R4", "curSector for match", curSector, 8'h85);
    streamSector(0);
    chk("R7", "busy after first of two sectors", busy, 1'b1);
    chk("R7", "no done flag yet", sectorDoneFlag, 1'b0);
    doHeader(1'b0, 7'd10, 7'd5);
    expectSilent("R7", "old target no longer matches");
    doHeader(1'b0, 7'd10, 7'd6);
    streamSector(1);
    chk("R7", "idle after last sector", busy, 1'b0);
    chk("R7", "done flag set", sectorDoneFlag, 1'b1);
    clearFlags();
    chk("R9", "done flag cleared", sectorDoneFlag, 1'b0);

    // R7 sweep including wrap from 127 to 0
    for (int f = 0; f < 4; f++) begin
      for (int n = 1; n <= 3; n++) begin
        logic [6:0] first;
        first = (f == 0) ? 7'd0 : (f == 1) ? 7'd63 : (f == 2) ? 7'd126 : 7'd127;
        doStart(first, 8'(n));
        doSync();
        for (int k = 0; k < n; k++) begin
          logic [6:0] want;
          want = 7'((int'(first) + k) % 128);
          doHeader(1'(k), 7'(f), 7'((int'(want) + 5) % 128));
          expectSilent("R5", "sweep mismatch silent");
          doHeader(1'(k), 7'(f), want);
          chk("R4", "sweep curSector", curSector, {1'b1, want});
          streamSector(k + f);
          chk("R7", "sweep busy after sector", busy, (k < n - 1) ? 1'b1 : 1'b0);
        end
        chk("R7", "sweep done flag", sectorDoneFlag, 1'b1);
        clearFlags();
      end
    end

    // R7: count of zero reads one sector
    doStart(7'd40, 8'd0);
    doSync();
    doHeader(1'b0, 7'd1, 7'd40);
    streamSector(2);
    chk("R7", "zero count reads one sector", busy, 1'b0);
    clearFlags();

    // R2: start while running keeps old target
    doStart(7'd10, 8'd1);
    doSync();
    doStart(7'd20, 8'd3);
    doHeader(1'b0, 7'd2, 7'd20);
    expectSilent("R2", "start while busy does not reload target");
    doHeader(1'b0, 7'd2, 7'd10);
    streamSector(0);
    chk("R2", "start while busy kept old count", busy, 1'b0);
    clearFlags();

    // R8: stop during sync wait
    doStart(7'd30, 8'd1);
    stopPulse = 1'b1;
    tick();
    stopPulse = 1'b0;
    chk("R8", "idle after stop in sync wait", busy, 1'b0);
    doSync();
    doHeader(1'b1, 7'd3, 7'd30);
    chk("R8", "no capture after stop", curSector, 8'h8A);
    chk("R8", "no ID flag after stop", idReadFlag, 1'b0);

    // R8: stop mid-sector
    doStart(7'd30, 8'd2);
    doSync();
    doHeader(1'b1, 7'd3, 7'd30);
    for (int b = 0; b < 3; b++) begin
      srcValid = 1'b1;
      dmaReady = 1'b1;
      tick();
    end
    stopPulse = 1'b1;
    tick();
    stopPulse = 1'b0;
    chk("R8", "idle after stop mid-sector", busy, 1'b0);
    expectSilent("R8", "output silent after stop");
    chk("R8", "no done flag after stop", sectorDoneFlag, 1'b0);

    // R8: stop wins over start
    startPulse = 1'b1;
    stopPulse  = 1'b1;
    tick();
    startPulse = 1'b0;
    stopPulse  = 1'b0;
    chk("R8", "stop wins over same-cycle start", busy, 1'b0);

    // R9: set wins over clear
    clearFlags();
    doStart(7'd1, 8'd1);
    doSync();
    irqClear = 1'b1;
    doHeader(1'b0, 7'd4, 7'd9);
    irqClear = 1'b0;
    chk("R9", "set wins over clear", idReadFlag, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule